// File: doc/BRIEF.md
# Handshaked Word Output Port

This block moves the 16-bit words of one buffered event out onto a parallel bus. It pulls words from an upstream FIFO (valid, data, end-of-event flag, pop) and presents each word on the bus together with a write strobe. A downstream receiver answers with an acknowledge. Several such ports can be chained: each waits for a readout-enable token, sends its event, and then raises a one-cycle pass pulse so that the next port can start.

Two transfer modes are available, chosen per event by a mode input that is sampled when the token starts the event. In handshake mode each word follows a strict strobe/acknowledge cycle with fixed setup and recovery gaps. In streaming mode words leave at a fixed rate of one per four cycles (10 MHz at the intended 40 MHz clock), and the strobe is a fixed-width marker. In that mode the acknowledge does not complete a handshake: it only holds back the next word while it is high.

Top module: `evt_word_tx`

## Requirements
- R1: While reset is asserted, and right after it, strobe_o, pass_o and src_pop_o are 0 and bus_o is 0.
- R2: A word is on bus_o for exactly one cycle with the strobe low before strobe_o rises, and bus_o does not change while strobe_o is high.
- R3: In handshake mode strobe_o stays high for at least 2 cycles and falls only after ack_i has been sampled high; in streaming mode it is high for exactly 2 cycles per word.
- R4: In handshake mode, when the FIFO holds the next word, strobe_o rises again exactly 2 clock edges after the first edge that samples ack_i low.
- R5: In streaming mode (fast_mode_i = 1 at event start) each word holds the bus for 4 cycles, and strobe_o is high in the 2nd and 3rd of them, so consecutive strobe rises are 4 cycles apart.
- R6: In streaming mode, ack_i sampled high at the end of a word slot holds back the next word (strobe low, nothing popped) until ack_i is low again.
- R7: An event starts only on a rising edge of token_i. While the block is idle, a token held high starts nothing and no word is popped.
- R8: pass_o is a pulse of exactly one cycle after the last word (src_last_i = 1) has been sent. In handshake mode it is high in the cycle after the edge that samples ack_i low for that word. In streaming mode it comes right after the last slot.
- R9: If the FIFO is empty in the middle of an event, bus_o is 0 and strobe_o is low until a word arrives, and the event then goes on.
- R10: Words leave in FIFO order, one pop per word, and the word flagged last ends the event.
- R11: The mode is taken from fast_mode_i when the event starts; changing fast_mode_i during an event does not change how that event is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (40 MHz intended) |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fast_mode_i | input | 1 | 1 = streaming mode, 0 = handshake mode; sampled at event start |
| token_i | input | 1 | Readout-enable token; a rising edge starts an event |
| ack_i | input | 1 | Write acknowledge from the receiver |
| src_valid_i | input | 1 | Upstream FIFO holds a word |
| src_data_i | input | 16 | Word at the head of the upstream FIFO |
| src_last_i | input | 1 | Head word is the last word of its event |
| src_pop_o | output | 1 | Removes the head word from the upstream FIFO |
| bus_o | output | 16 | Output data bus, 0 when no word is being presented |
| strobe_o | output | 1 | Write strobe |
| pass_o | output | 1 | One-cycle token hand-off to the next port |

## Verification
The bench measures the recovery gap from the exact edge at which the acknowledge drops. A design that waits one cycle too many or too few after release, or that uses the wrong edge, is off by one in that count. It also stretches the acknowledge to catch a strobe that drops on its width counter alone, and it leaves the FIFO empty in the middle of an event to catch a bus that carries stale data or a strobe that pulses over nothing. In streaming mode it checks the four-cycle spacing while flipping the mode input in the middle of an event, so a design that does not latch the mode turns to handshaking. It also raises the acknowledge at a slot boundary, so a design that ignores the pause keeps sending words. A token that is still high after an event, and words pushed before any token, catch a port that starts on the token level instead of its edge.

// File: rtl/ohp_pkg.sv
package ohp_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_HOLD,
    ST_RELEASE,
    ST_GAP,
    ST_SLOT,
    ST_PASS
  } ohp_state_e;

endpackage

// File: rtl/ohp_rst_sync.sv
module ohp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ohp_edge_det.sv
module ohp_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
    end
  end

  assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/ohp_word_reg.sv
module ohp_word_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         last_i,
  input  logic         drive_i,
  output logic [W-1:0] bus_o,
  output logic         last_o
);

  logic [W-1:0] word_q;
  logic         last_q;

  // Word holding register with explicit load enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      last_q <= 1'b0;
    end else if (load_i) begin
      word_q <= data_i;
      last_q <= last_i;
    end
  end

  assign bus_o  = drive_i ? word_q : '0;
  assign last_o = last_q;

endmodule

// File: rtl/ohp_ctrl.sv
module ohp_ctrl
  import ohp_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int MIN_HI    = 2,
  parameter int GAP_CYC   = 2,
  parameter int SLOT_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fast_i,
  input  logic ack_i,
  input  logic src_valid_i,
  input  logic last_i,
  output logic load_o,
  output logic drive_o,
  output logic strobe_o,
  output logic pass_o,
  output logic fast_o
);

  // Extra recovery beyond the fetch cycle plus the setup cycles.
  localparam int GAP_EXTRA = (GAP_CYC > SETUP_CYC + 1) ? GAP_CYC - SETUP_CYC - 1 : 0;
  localparam int M1        = (SETUP_CYC > MIN_HI) ? SETUP_CYC : MIN_HI;
  localparam int M2        = (M1 > SLOT_CYC) ? M1 : SLOT_CYC;
  localparam int CNT_MAX   = (M2 > GAP_EXTRA) ? M2 : GAP_EXTRA;
  localparam int CW        = $clog2(CNT_MAX + 1);

  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HI_LAST    = CW'(MIN_HI - 1);
  localparam logic [CW-1:0] SLOT_LAST  = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'((GAP_EXTRA > 0) ? GAP_EXTRA - 1 : 0);
  localparam logic [CW-1:0] WIN_LO     = CW'(SETUP_CYC);
  localparam logic [CW-1:0] WIN_HI     = CW'(SETUP_CYC + MIN_HI - 1);

  ohp_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fast_q, fast_d;
  logic          strobe_q, strobe_d;
  logic          pass_q, pass_d;
  logic          drive_q, drive_d;
  logic          load;

  // Next-state process.
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fast_d  = fast_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          fast_d  = fast_i;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (src_valid_i && (!fast_q || !ack_i)) begin
          load    = 1'b1;
          cnt_d   = '0;
          state_d = fast_q ? ST_SLOT : ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (cnt_q == SETUP_LAST) begin
          cnt_d   = '0;
          state_d = ST_HOLD;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_q < HI_LAST) begin
          cnt_d = cnt_q + 1'b1;
        end else if (ack_i) begin
          state_d = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        if (!ack_i) begin
          cnt_d = '0;
          if (last_i) begin
            state_d = ST_PASS;
          end else if (GAP_EXTRA == 0) begin
            state_d = ST_FETCH;
          end else begin
            state_d = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (cnt_q == GAP_LAST) begin
          state_d = ST_FETCH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SLOT: begin
        if (cnt_q == SLOT_LAST) begin
          if (last_i) begin
            state_d = ST_PASS;
          end else if (src_valid_i && !ack_i) begin
            load  = 1'b1;
            cnt_d = '0;
          end else begin
            state_d = ST_FETCH;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PASS: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase

    strobe_d = (state_d == ST_HOLD) ||
               ((state_d == ST_SLOT) && (cnt_d >= WIN_LO) && (cnt_d <= WIN_HI));
    pass_d   = (state_d == ST_PASS);
    drive_d  = (state_d == ST_SETUP) || (state_d == ST_HOLD) ||
               (state_d == ST_RELEASE) || (state_d == ST_SLOT);
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      fast_q   <= 1'b0;
      strobe_q <= 1'b0;
      pass_q   <= 1'b0;
      drive_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      fast_q   <= fast_d;
      strobe_q <= strobe_d;
      pass_q   <= pass_d;
      drive_q  <= drive_d;
    end
  end

  assign load_o   = load;
  assign drive_o  = drive_q;
  assign strobe_o = strobe_q;
  assign pass_o   = pass_q;
  assign fast_o   = fast_q;

  // R3: strobe never shorter than the minimum width.
  a_r3_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_q) |-> $past(strobe_q, 2));

  // R3: in handshake mode strobe falls only after acknowledge was seen.
  a_r3_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strobe_q) && !fast_q) |-> $past(ack_i));

  // R8: pass is a single-cycle pulse.
  a_r8_pass_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |=> !pass_q);

  // R9: while waiting for a word the bus is idle and strobe is low.
  a_r9_fetch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |-> (!strobe_q && !drive_q));

  // R6: acknowledge at a slot boundary blocks the next word.
  a_r6_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q && ack_i) |-> !load);

  // R7: nothing popped while idle.
  a_r7_idle_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !load);

endmodule

// File: rtl/evt_word_tx.sv
module evt_word_tx
  import ohp_pkg::*;
#(
  parameter int W         = WORD_W,
  parameter int SETUP_CYC = 1,
  parameter int MIN_HI    = 2,
  parameter int GAP_CYC   = 2,
  parameter int SLOT_CYC  = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         fast_mode_i,
  input  logic         token_i,
  input  logic         ack_i,
  input  logic         src_valid_i,
  input  logic [W-1:0] src_data_i,
  input  logic         src_last_i,
  output logic         src_pop_o,
  output logic [W-1:0] bus_o,
  output logic         strobe_o,
  output logic         pass_o
);

  logic rst_n;
  logic start;
  logic load;
  logic drive;
  logic last_q;
  logic fast_q;

  ohp_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  ohp_edge_det u_tok (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (token_i),
    .rise_o (start)
  );

  ohp_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .MIN_HI    (MIN_HI),
    .GAP_CYC   (GAP_CYC),
    .SLOT_CYC  (SLOT_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .fast_i      (fast_mode_i),
    .ack_i       (ack_i),
    .src_valid_i (src_valid_i),
    .last_i      (last_q),
    .load_o      (load),
    .drive_o     (drive),
    .strobe_o    (strobe_o),
    .pass_o      (pass_o),
    .fast_o      (fast_q)
  );

  ohp_word_reg #(.W(W)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .data_i  (src_data_i),
    .last_i  (src_last_i),
    .drive_i (drive),
    .bus_o   (bus_o),
    .last_o  (last_q)
  );

  assign src_pop_o = load;

  // R2: the word is settled on the bus before strobe rises.
  a_r2_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> $stable(bus_o));

  // R2: bus stays still while strobe is high.
  a_r2_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && $past(strobe_o)) |-> $stable(bus_o));

  // R10: a pop happens only when the FIFO holds a word.
  a_r10_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop_o |-> src_valid_i);

  // R5: a streaming-mode strobe is followed by one more high cycle.
  a_r5_fast_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strobe_o) && fast_q) |=> strobe_o);

endmodule

// File: tb/test_evt_word_tx.sv
module test_evt_word_tx;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        fast_mode_i;
  logic        token_i;
  logic        ack_i;
  logic        src_valid_i;
  logic [15:0] src_data_i;
  logic        src_last_i;
  logic        src_pop_o;
  logic [15:0] bus_o;
  logic        strobe_o;
  logic        pass_o;

  always #4 clk = ~clk;

  evt_word_tx i_evt_word_tx (
    .clk         (clk),
    .arst_n      (arst_n),
    .fast_mode_i (fast_mode_i),
    .token_i     (token_i),
    .ack_i       (ack_i),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .src_last_i  (src_last_i),
    .src_pop_o   (src_pop_o),
    .bus_o       (bus_o),
    .strobe_o    (strobe_o),
    .pass_o      (pass_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [16:0] src_q[$];
  logic [15:0] exp_q[$];

  // Bench-side expectations and responder settings.
  bit    exp_fast    = 0;
  bit    gap_chk     = 0;
  bit    space_chk   = 0;
  string space_tag   = "R5";
  bit    resp_en     = 0;
  int    hs_dly      = 0;
  int    hs_hold     = 0;
  int    rel_cyc     = 0;
  bit    rel_valid   = 0;
  bit    mon_en      = 0;
  int    n_rise      = 0;
  int    n_pass      = 0;
  bit    done        = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic void refresh();
    src_valid_i = (src_q.size() != 0);
    src_data_i  = src_valid_i ? src_q[0][15:0] : 16'h0;
    src_last_i  = src_valid_i ? src_q[0][16] : 1'b0;
  endfunction

  task automatic push_word(input logic [15:0] d, input bit last);
    src_q.push_back({last, d});
    exp_q.push_back(d);
    refresh();
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Upstream FIFO: pop after the edge that took the word.
  logic pop_seen = 1'b0;
  always @(posedge clk) pop_seen <= src_pop_o;
  always @(posedge clk) begin
    #2;
    if (pop_seen && src_q.size() != 0) begin
      void'(src_q.pop_front());
      refresh();
    end
  end

  // Handshake receiver model.
  int wcnt = 0;
  always @(posedge clk) begin
    #2;
    if (resp_en) begin
      if (!ack_i && strobe_o) begin
        if (wcnt >= hs_dly) begin ack_i = 1'b1; wcnt = 0; end
        else wcnt++;
      end else if (ack_i && !strobe_o) begin
        if (wcnt >= hs_hold) begin
          ack_i = 1'b0; wcnt = 0; rel_cyc = cyc; rel_valid = 1;
        end else wcnt++;
      end
    end
  end

  // Monitor / scoreboard.
  logic        st_prev = 0, pass_prev = 0, ack_prev = 0;
  logic [15:0] bus_prev = 0;
  int          hi_len = 0;
  int          last_rise = -1;
  always @(negedge clk) begin
    if (mon_en) begin
      if (strobe_o && !st_prev) begin
        n_rise++;
        if (exp_q.size() == 0) begin
          check(0, "R10", "unexpected word", bus_o, 0);
        end else begin
          check(bus_o == exp_q[0], "R10", "word order", bus_o, exp_q[0]);
          void'(exp_q.pop_front());
        end
        check(bus_o == bus_prev, "R2", "setup cycle data", bus_prev, bus_o);
        if (exp_fast && space_chk && last_rise >= 0)
          check(cyc - last_rise == 4, space_tag, "slot spacing", cyc - last_rise, 4);
        if (!exp_fast && gap_chk && rel_valid)
          check(cyc - rel_cyc == 3, "R4", "recovery gap", cyc - rel_cyc, 3);
        last_rise = cyc;
        hi_len = 1;
      end else if (strobe_o) begin
        hi_len++;
        check(bus_o == bus_prev, "R2", "bus stable under strobe", bus_o, bus_prev);
      end
      if (!strobe_o && st_prev) begin
        if (exp_fast) check(hi_len == 2, "R3", "fast strobe width", hi_len, 2);
        else begin
          check(hi_len >= 2, "R3", "strobe width", hi_len, 2);
          check(ack_prev == 1'b1, "R3", "fell without ack", ack_prev, 1);
        end
      end
      if (pass_o && !pass_prev) begin
        n_pass++;
        check(exp_q.size() == 0, "R8", "pass before all words", exp_q.size(), 0);
        if (!exp_fast && rel_valid)
          check(cyc - rel_cyc == 1, "R8", "pass timing", cyc - rel_cyc, 1);
      end
      if (pass_prev) check(!pass_o, "R8", "pass width", pass_o, 0);
    end
    st_prev   = strobe_o;
    pass_prev = pass_o;
    ack_prev  = ack_i;
    bus_prev  = bus_o;
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_pass(input int target);
    int t = 0;
    while (n_pass < target && t < 3000) begin
      @(posedge clk);
      t++;
    end
    #2;
    check(n_pass >= target, "R8", "pass seen", n_pass, target);
  endtask

  task automatic start_event(input bit fast, input bit gchk);
    exp_fast    = fast;
    gap_chk     = gchk;
    rel_valid   = 0;
    last_rise   = -1;
    fast_mode_i = fast;
    token_i     = 1'b1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    arst_n = 1'b0; fast_mode_i = 1'b0; token_i = 1'b0; ack_i = 1'b0;
    refresh();
    wait_cycles(4);
    @(negedge clk);
    check(strobe_o == 0, "R1", "strobe in reset", strobe_o, 0);
    check(pass_o == 0, "R1", "pass in reset", pass_o, 0);
    check(bus_o == 0, "R1", "bus in reset", bus_o, 0);
    check(src_pop_o == 0, "R1", "pop in reset", src_pop_o, 0);
    @(posedge clk); #2;
    arst_n = 1'b1;
    mon_en = 1;
    wait_cycles(4);

    // R7: words waiting, no token -> nothing happens.
    push_word(16'hA001, 0); push_word(16'hA002, 0); push_word(16'hA003, 1);
    wait_cycles(10);
    check(src_q.size() == 3, "R7", "popped without token", src_q.size(), 3);
    check(n_rise == 0, "R7", "strobe without token", n_rise, 0);

    // Handshake event, FIFO preloaded (R2 R3 R4 R8 R10).
    resp_en = 1; hs_dly = 0; hs_hold = 0;
    start_event(0, 1);
    wait_pass(1);
    check(n_rise == 3, "R10", "words sent", n_rise, 3);

    // R7: token still high after the event does not restart.
    push_word(16'hB0B0, 0); push_word(16'h0000, 1);
    wait_cycles(12);
    check(src_q.size() == 2, "R7", "restart on level", src_q.size(), 2);
    token_i = 1'b0;
    wait_cycles(2);

    // Slow receiver (R3 waits for ack, R4 gap from release).
    hs_dly = 3; hs_hold = 2;
    start_event(0, 1);
    wait_pass(2);
    check(n_rise == 5, "R10", "words sent slow rx", n_rise, 5);
    token_i = 1'b0;
    wait_cycles(2);

    // R9: FIFO runs dry mid-event.
    hs_dly = 0; hs_hold = 0;
    push_word(16'h1111, 0); push_word(16'h2222, 0);
    start_event(0, 0);
    wait_cycles(20);
    check(n_rise == 7, "R9", "words before starve", n_rise, 7);
    begin
      int bad = 0;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (strobe_o || bus_o != 0 || pass_o) bad++;
      end
      check(bad == 0, "R9", "bus busy while empty", bad, 0);
    end
    @(posedge clk); #2;
    push_word(16'h3333, 1);
    wait_pass(3);
    check(n_rise == 8, "R9", "resume after starve", n_rise, 8);
    token_i = 1'b0;
    wait_cycles(2);

    // Streaming event; mode input flipped mid-event (R5 R11).
    resp_en = 0; ack_i = 1'b0;
    for (int i = 0; i < 5; i++) push_word(16'hC000 + 16'(i), i == 4);
    space_chk = 1; space_tag = "R11";
    start_event(1, 0);
    wait_cycles(6);
    fast_mode_i = 1'b0;
    wait_pass(4);
    check(n_rise == 13, "R5", "fast words sent", n_rise, 13);
    token_i = 1'b0;
    wait_cycles(2);

    // Streaming with pause (R6).
    space_tag = "R5";
    for (int i = 0; i < 6; i++) push_word(16'hD000 + 16'(i), i == 5);
    start_event(1, 0);
    base = n_rise;
    while (n_rise < base + 2) @(negedge clk);
    space_chk = 0;
    @(posedge clk); #2;
    ack_i = 1'b1;
    wait_cycles(12);
    check(n_rise == base + 2, "R6", "words during pause", n_rise - base, 2);
    check(src_q.size() == 4, "R6", "pops during pause", src_q.size(), 4);
    check(strobe_o == 0, "R6", "strobe during pause", strobe_o, 0);
    ack_i = 1'b0;
    wait_pass(5);
    check(n_rise == base + 6, "R6", "words after pause", n_rise - base, 6);
    token_i = 1'b0;
    wait_cycles(4);

    check(exp_q.size() == 0, "R10", "words left over", exp_q.size(), 0);
    check(n_pass == 5, "R8", "pass count", n_pass, 5);
    done = 1;
    summary();
    $finish;
  end

endmodule